// File: doc/BRIEF.md
# Programmable DMA Channel Sequencer

This block is one programmable direct-memory-access channel. Software sets it up through a small write port. The setup covers a starting address, a transfer count, a fixed upper-address (page) value and a control word. Once set up, the channel watches a peripheral request line. It asks for the system bus, and when the bus is granted it runs transfers. Each transfer holds the acknowledge line, drives a 16-bit address with a strobe, and then steps its address and count registers.

The channel has two ways of running. In single mode it performs one transfer per request and then gives the bus back. In block mode it keeps transferring until the count is used up or an external end-of-process input ends the run. When a run ends, one of two things happens. With auto-initialization off, the channel masks itself. With it on, the channel restores its working registers from the programmed base values and stays armed. The page output is a separate latch. It never takes a carry from the 16-bit address counter, so an address that wraps stays inside the same page.

Top module: `dmach_top`

## Requirements
- R1: After a synchronous reset, all of the following are 0: `hrq`, `dack`, `mem_rd`, `mem_wr`, `tc`, `addr` and `page`. The channel also starts masked, so a request is ignored until the control word is written.
- R2: Writes use the select field `cfg_sel`. Select 0 writes the base address, select 1 the base count, select 2 the page and select 3 the control word. Writing the base address or the base count also loads the matching working register, and a written address appears on `addr` one cycle after the write.
- R3: The control word has these bits: bit0 selects block mode, bit1 selects a decrementing address, bit2 enables auto-init, bit3 makes the transfer a memory write, and bit4 is the mask. When the channel is unmasked and idle, a sampled `dreq` raises `hrq` on the next cycle. Once `bus_grant` is seen, each transfer is three cycles long: address, strobe and update, with `dack` high through all three.
- R4: During the strobe cycle exactly one strobe is high. It is `mem_wr` when control bit3 is 1 and `mem_rd` otherwise. `addr` holds the transfer's address through both the address cycle and the strobe cycle.
- R5: After each transfer the 16-bit address moves up or down by 1, depending on control bit1. It wraps modulo 65536.
- R6: `page` changes only through a select-2 write. It is never changed by a transfer, including one that wraps the address.
- R7: A programmed count N gives N transfers. `tc` is high during the update cycle of the transfer that brings the count to zero, and that run then ends.
- R8: In single mode the channel does one transfer per request and then drops `hrq`, even while `dreq` stays high.
- R9: In block mode transfers follow each other back to back, with no return to idle, until end of process.
- R10: An end-of-process input seen during a transfer's address, strobe or update cycle lets that transfer finish, and then the run ends. No `tc` pulse occurs unless the count also reaches zero.
- R11: When a run ends, the auto-init setting decides what happens. With auto-init on, the address and count reload from their base values and the channel stays unmasked. With auto-init off, the address and count keep their stepped values and the mask bit is set.
- R12: While the mask bit is set, `dreq` is ignored and `hrq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Setup write enable |
| cfg_sel | input | 2 | Setup register select (0 addr, 1 count, 2 page, 3 control) |
| cfg_wdata | input | 16 | Setup write data |
| dreq | input | 1 | Peripheral transfer request |
| bus_grant | input | 1 | System bus granted to the channel |
| eop_in | input | 1 | External end-of-process |
| hrq | output | 1 | Bus request |
| dack | output | 1 | Peripheral acknowledge, high through each transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr | output | 16 | Current transfer address |
| page | output | 8 | Upper address latch |
| tc | output | 1 | Terminal count pulse |

## Verification
All inputs are driven on the falling edge, so the cycle in which each result appears can be counted. If `dreq` goes high before rising edge k, `hrq` is high after edge k. With the grant already present, `dack` follows after edge k+1, the strobe after k+2, and the update cycle (which carries `tc`) after k+3. The stepped address and the release of `hrq` in single mode appear after edge k+4. Timing checks sample on the falling edge that follows each of those rising edges. Run-level checks count strobes and `tc` pulses on every falling edge until `hrq` falls, and then compare the address, the page and the mask state. The mask state is read back by raising `dreq` once more and looking at `hrq` one cycle later.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int CTRL_W = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_ADDR,
        PH_STRB,
        PH_UPDT
    } phase_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_CTRL = 2'd3
    } csel_e;

    // bit4 mask, bit3 memory write, bit2 auto-init, bit1 decrement, bit0 block
    typedef struct packed {
        logic mask;
        logic to_mem;
        logic auto_init;
        logic down;
        logic burst;
    } chan_ctrl_t;

    localparam chan_ctrl_t CTRL_RESET = '{mask: 1'b1, default: 1'b0};

    function automatic phase_e next_phase(input phase_e cur, input logic req,
                                          input logic grant, input logic stop);
        case (cur)
            PH_IDLE: return req   ? PH_REQ  : PH_IDLE;
            PH_REQ:  return grant ? PH_ADDR : PH_REQ;
            PH_ADDR: return PH_STRB;
            PH_STRB: return PH_UPDT;
            PH_UPDT: return stop  ? PH_IDLE : PH_ADDR;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          adv,
    input  logic          reload,
    input  logic          halt,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output chan_ctrl_t    ctrl
);

    logic [AW-1:0] base_addr;
    logic [CW-1:0] base_cnt;
    logic          unused_cfg;

    assign unused_cfg = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            page      <= '0;
            ctrl      <= CTRL_RESET;
        end else if (cfg_we) begin
            case (csel_e'(cfg_sel))
                SEL_ADDR: begin
                    base_addr <= cfg_wdata;
                    cur_addr  <= cfg_wdata;
                end
                SEL_CNT: begin
                    base_cnt <= cfg_wdata[CW-1:0];
                    cur_cnt  <= cfg_wdata[CW-1:0];
                end
                SEL_PAGE: page <= cfg_wdata[PW-1:0];
                default:  ctrl <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            endcase
        end else if (adv) begin
            if (reload) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= ctrl.down ? cur_addr - 1'b1 : cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
            end
            if (halt) ctrl.mask <= 1'b1;
        end
    end

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dreq,
    input  logic bus_grant,
    input  logic eop_in,
    input  logic masked,
    input  logic burst,
    input  logic auto_init,
    input  logic to_mem,
    input  logic cnt_last,
    output logic hrq,
    output logic dack,
    output logic mem_rd,
    output logic mem_wr,
    output logic tc,
    output logic adv,
    output logic reload,
    output logic halt
);

    phase_e phase, phase_nx;
    logic   eop_seen;
    logic   in_xfer;
    logic   run_end;
    logic   stop;

    assign in_xfer = (phase == PH_ADDR) || (phase == PH_STRB) || (phase == PH_UPDT);
    assign run_end = cnt_last || eop_seen || eop_in;
    assign stop    = run_end || !burst;
    assign phase_nx = next_phase(phase, dreq && !masked, bus_grant, stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            eop_seen <= 1'b0;
        end else begin
            phase <= phase_nx;
            if (phase == PH_UPDT)
                eop_seen <= 1'b0;
            else if (in_xfer && eop_in)
                eop_seen <= 1'b1;
        end
    end

    assign hrq    = (phase != PH_IDLE);
    assign dack   = in_xfer;
    assign mem_rd = (phase == PH_STRB) && !to_mem;
    assign mem_wr = (phase == PH_STRB) && to_mem;
    assign adv    = (phase == PH_UPDT);
    assign tc     = adv && cnt_last;
    assign reload = adv && run_end && auto_init;
    assign halt   = adv && run_end && !auto_init;

endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dreq,
    input  logic          bus_grant,
    input  logic          eop_in,
    output logic          hrq,
    output logic          dack,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] addr,
    output logic [PW-1:0] page,
    output logic          tc
);

    logic [CW-1:0] cur_cnt;
    chan_ctrl_t    ctrl;
    logic          adv, reload, halt;
    logic          cnt_last;

    assign cnt_last = (cur_cnt == CW'(1));

    dmach_regs #(.AW(AW), .CW(CW), .PW(PW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .adv       (adv),
        .reload    (reload),
        .halt      (halt),
        .cur_addr  (addr),
        .cur_cnt   (cur_cnt),
        .page      (page),
        .ctrl      (ctrl)
    );

    dmach_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .dreq      (dreq),
        .bus_grant (bus_grant),
        .eop_in    (eop_in),
        .masked    (ctrl.mask),
        .burst     (ctrl.burst),
        .auto_init (ctrl.auto_init),
        .to_mem    (ctrl.to_mem),
        .cnt_last  (cnt_last),
        .hrq       (hrq),
        .dack      (dack),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .tc        (tc),
        .adv       (adv),
        .reload    (reload),
        .halt      (halt)
    );

endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic          bus_grant,
    input logic          hrq,
    input logic          dack,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          tc,
    input logic [AW-1:0] addr,
    input logic [PW-1:0] page
);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_strobe_in_dack_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> dack);

    p_strobe_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

    p_dack_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dack) |-> $past(bus_grant) && $past(hrq));

    p_addr_held_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> $stable(addr));

    p_page_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(page));

    p_tc_in_update_r7: assert property (@(posedge clk) disable iff (rst)
        tc |-> dack && !mem_rd && !mem_wr);

    p_tc_releases_r7: assert property (@(posedge clk) disable iff (rst)
        tc |=> !hrq);

endmodule

bind dmach_top dmach_chk #(.AW(AW), .PW(PW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .bus_grant (bus_grant),
    .hrq       (hrq),
    .dack      (dack),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .tc        (tc),
    .addr      (addr),
    .page      (page)
);

// File: tb/dmach_top_tb_top.sv
module dmach_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        dreq = 1'b0;
    logic        bus_grant = 1'b1;
    logic        eop_in = 1'b0;
    logic        hrq, dack, mem_rd, mem_wr, tc;
    logic [15:0] addr;
    logic [7:0]  page;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dmach_top dut_i (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .dreq (dreq), .bus_grant (bus_grant),
        .eop_in (eop_in), .hrq (hrq), .dack (dack), .mem_rd (mem_rd),
        .mem_wr (mem_wr), .addr (addr), .page (page), .tc (tc)
    );

    // control bits: 0 block, 1 decrement, 2 auto-init, 3 memory write, 4 mask
    typedef struct packed {
        logic [15:0] a0;
        logic [15:0] cnt;
        logic [4:0]  ctrl;
        logic [15:0] exp_addr;
        logic [15:0] exp_n;
        logic        exp_masked;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h1000, 16'd3, 5'h01, 16'h1003, 16'd3, 1'b1},
        '{16'h2000, 16'd4, 5'h03, 16'h1FFC, 16'd4, 1'b1},
        '{16'hFFFE, 16'd4, 5'h09, 16'h0002, 16'd4, 1'b1},
        '{16'h0001, 16'd3, 5'h03, 16'hFFFE, 16'd3, 1'b1},
        '{16'h3000, 16'd2, 5'h05, 16'h3000, 16'd2, 1'b0},
        '{16'h0500, 16'd1, 5'h00, 16'h0501, 16'd1, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] n,
                         input logic [7:0] pg, input logic [4:0] c);
        wr(2'd0, a);
        wr(2'd1, n);
        wr(2'd2, {8'h00, pg});
        wr(2'd3, {11'h000, c});
    endtask

    // raise dreq, count strobes and tc until hrq falls; optional eop on strobe number eop_at
    task automatic run_xfer(input int eop_at, output int nrd, output int nwr, output int ntc);
        int guard = 0;
        int nstb = 0;
        bit seen = 0;
        nrd = 0; nwr = 0; ntc = 0;
        @(negedge clk);
        dreq = 1'b1;
        forever begin
            @(negedge clk);
            eop_in = 1'b0;
            if (hrq) begin seen = 1; dreq = 1'b0; end
            if (mem_rd) nrd++;
            if (mem_wr) nwr++;
            if (mem_rd || mem_wr) begin
                nstb++;
                if (nstb == eop_at) eop_in = 1'b1;
            end
            if (tc) ntc++;
            if (seen && !hrq) break;
            guard++;
            if (guard > 2000) begin
                chk("R9", "run did not end", 0, 1);
                break;
            end
        end
        dreq = 1'b0;
    endtask

    // mask state through the ports: raise dreq and look at hrq one cycle later
    task automatic probe(input string req, input logic exp_h);
        int guard = 0;
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        chk(req, "hrq after probe request", hrq, exp_h);
        dreq = 1'b0;
        while (hrq && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int nrd, nwr, ntc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "hrq", hrq, 0);
        chk("R1", "dack", dack, 0);
        chk("R1", "strobes", {mem_rd, mem_wr}, 0);
        chk("R1", "tc", tc, 0);
        chk("R1", "addr", addr, 0);
        chk("R1", "page", page, 0);
        probe("R1", 1'b0);

        // R2: base address write appears on addr next cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h7777;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R2", "addr after base write", addr, 16'h7777);

        // table of block and single runs (R5 R6 R7 R9 R11)
        for (int i = 0; i < NV; i++) begin
            setup(VECS[i].a0, VECS[i].cnt, 8'h10 + 8'(i), VECS[i].ctrl);
            run_xfer(0, nrd, nwr, ntc);
            chk("R5", $sformatf("vec%0d addr", i), addr, VECS[i].exp_addr);
            if (VECS[i].ctrl[3]) begin
                chk("R4", $sformatf("vec%0d wr strobes", i), nwr, VECS[i].exp_n);
                chk("R4", $sformatf("vec%0d rd strobes", i), nrd, 0);
            end else begin
                chk("R7", $sformatf("vec%0d rd strobes", i), nrd, VECS[i].exp_n);
                chk("R4", $sformatf("vec%0d wr strobes", i), nwr, 0);
            end
            chk("R7", $sformatf("vec%0d tc pulses", i), ntc, 1);
            chk("R6", $sformatf("vec%0d page", i), page, 8'h10 + 8'(i));
            probe("R11", !VECS[i].exp_masked);
        end

        // R3 R8: cycle timing of one single-mode transfer with dreq held
        setup(16'h0100, 16'd5, 8'h22, 5'h00);
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        chk("R3", "hrq after edge 1", hrq, 1);
        chk("R3", "dack after edge 1", dack, 0);
        @(negedge clk);
        chk("R3", "dack in address cycle", dack, 1);
        chk("R3", "no strobe in address cycle", mem_rd, 0);
        chk("R4", "addr in address cycle", addr, 16'h0100);
        @(negedge clk);
        chk("R3", "mem_rd in strobe cycle", mem_rd, 1);
        chk("R4", "addr in strobe cycle", addr, 16'h0100);
        @(negedge clk);
        chk("R3", "dack in update cycle", dack, 1);
        chk("R3", "no strobe in update cycle", mem_rd, 0);
        chk("R7", "no tc before count ends", tc, 0);
        @(negedge clk);
        chk("R8", "bus released with dreq held", hrq, 0);
        chk("R5", "addr stepped", addr, 16'h0101);
        dreq = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8", "no further transfer", hrq, 0);
        chk("R8", "addr unchanged", addr, 16'h0101);

        // R10: external eop in block mode, auto-init off
        setup(16'h4000, 16'd10, 8'h33, 5'h01);
        run_xfer(2, nrd, nwr, ntc);
        chk("R10", "strobes before eop end", nrd, 2);
        chk("R10", "no tc on eop end", ntc, 0);
        chk("R10", "addr after eop end", addr, 16'h4002);
        probe("R11", 1'b0);

        // R10 R11: external eop with auto-init reloads and stays armed
        setup(16'h4000, 16'd10, 8'h33, 5'h05);
        run_xfer(1, nrd, nwr, ntc);
        chk("R10", "one transfer before eop", nrd, 1);
        chk("R11", "addr reloaded", addr, 16'h4000);
        probe("R11", 1'b1);
        chk("R11", "addr reloaded after full run", addr, 16'h4000);

        // R12: mask bit blocks requests
        setup(16'h5000, 16'd3, 8'h44, 5'h11);
        @(negedge clk);
        dreq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12", "hrq while masked", hrq, 0);
        chk("R12", "addr while masked", addr, 16'h5000);
        dreq = 1'b0;

        done = 1;
        summary();
        $finish;
    end

endmodule